// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block gathers shared peripheral interrupt lines and per-CPU private interrupt lines. It holds per-interrupt enable, pending, active, priority, routing and trigger-mode state. For every CPU it picks the most urgent deliverable interrupt and presents that interrupt's ID and priority to the CPU interface. Software programs it through a 32-bit word-addressed register port. Each access carries the number of the CPU making it, and that number selects which copy of the private state the access touches.

IDs 0 to 31 are private: each CPU has its own enable, pending and active bits for them. IDs 0 to 15 are software-generated. IDs 16 to 31 come from per-CPU input pins. IDs 32 and up are shared lines, and their per-interrupt target masks steer them to CPUs. A CPU interface reports an acknowledge, which makes the ID active, and an end-of-interrupt, which makes it inactive again. A software-interrupt register raises a private software ID on a chosen set of CPUs.

Top module: `irq_dist_top`

## Requirements
- R1: After reset every enable, priority (0), target (0), trigger-mode and pending bit is clear and the global enable is off. Each CPU output shows valid 0, ID 1023 and priority 0xFF.
- R2: Word 0x040+w is enable-set and word 0x060+w is enable-clear. ID n is bit n%32 of word w=n/32. A 1 written to either register sets or clears that enable, and a written 0 has no effect. Both registers read back the current enables.
- R3: Word 0x100+n/4 holds the 8-bit priority of ID n in bits [8*(n%4)+7 : 8*(n%4)]. Priorities read back as written.
- R4: Word 0x200+n/4 holds the target mask of ID n in the same byte lanes, and bit k routes the ID to CPU k. The words for private IDs 0 to 31 read as zero and ignore writes.
- R5: Word 0x001 is read-only and returns NUM_LINES/32-1 in bits [4:0].
- R6: Bit 0 of word 0x000 is the global enable. While it is 0, no CPU output is valid.
- R7: Each CPU output shows the enabled, pending, non-active ID routed to that CPU that has the lowest priority value. On a tie the lower ID wins. When no such ID exists, the output shows ID 1023 and priority 0xFF with valid low.
- R8: For IDs 0 to 31 the enable, pending and active bits are separate per CPU. An access with reg_cpu=k reads and changes only CPU k's copy.
- R9: Word 0x300+n/16 holds the 2-bit trigger field of ID n at bits [2*(n%16)+1 : 2*(n%16)]. Field bit 1 = 1 selects edge mode: a rising input edge latches pending. Field bit 0 is not stored and reads 0.
- R10: In level mode an ID is pending exactly while its input is high and it is not active. It reads as not pending after the input falls. Pending is read at word 0x080+w and active at word 0x0A0+w, with the same bit layout as R2.
- R11: A write to word 0x3C0 makes ID wdata[3:0] pending on every CPU k whose bit wdata[16+k] is set, and on no other CPU.
- R12: An acknowledge from a CPU makes the ID active and clears its latched pending state. An end-of-interrupt clears the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_cpu | input | CPU_W | Number of the CPU making the access (selects private bank) |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| spi_in | input | NUM_LINES-32 | Shared interrupt inputs; bit j is ID j+32 |
| priv_in | input | NUM_CPUS*16 | Private inputs; bit 16*k+m is ID 16+m of CPU k |
| ack_valid | input | NUM_CPUS | Acknowledge strobe per CPU |
| ack_id | input | NUM_CPUS*10 | Acknowledged ID per CPU |
| eoi_valid | input | NUM_CPUS | End-of-interrupt strobe per CPU |
| eoi_id | input | NUM_CPUS*10 | Completed ID per CPU |
| sel_valid | output | NUM_CPUS | Selected interrupt present, per CPU |
| sel_id | output | NUM_CPUS*10 | Selected ID per CPU |
| sel_prio | output | NUM_CPUS*8 | Priority of the selected ID per CPU |

## Verification
The bench aims at the tie between equal priorities. A selector with the wrong comparison would present the higher ID. It drops a level input before any acknowledge; a design that latched level inputs would keep delivering an interrupt that is gone. It writes enables for a private ID from one CPU and reads them from another, and it sends a software interrupt to a single CPU. A flaw in banking would show as state leaking to the wrong CPU. It also writes zeros to the enable registers and writes to the private target words. A design that treated these as plain stores would lose enables or invent routes.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int PRIV_IDS = 32;
  localparam int SGI_IDS  = 16;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  // word address map
  localparam logic [9:0] A_CTRL   = 10'h000;
  localparam logic [9:0] A_TYPE   = 10'h001;
  localparam logic [4:0] PG_ENSET = 5'h02;  // addr[9:5]
  localparam logic [4:0] PG_ENCLR = 5'h03;
  localparam logic [4:0] PG_PEND  = 5'h04;
  localparam logic [4:0] PG_ACT   = 5'h05;
  localparam logic [1:0] PG_PRIO  = 2'b01;  // addr[9:8]
  localparam logic [1:0] PG_TGT   = 2'b10;
  localparam logic [3:0] PG_CFG   = 4'hC;   // addr[9:6]
  localparam logic [9:0] A_SGI    = 10'h3C0;
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64,
  parameter int CPU_W     = 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr,
  input  logic                                   rd,
  input  logic [CPU_W-1:0]                       cpu,
  input  logic [9:0]                             addr,
  input  logic [31:0]                            wdata,
  output logic [31:0]                            rdata,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]     pend_view,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]     act_view,
  output logic                                   gen_en,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0]     en_view,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]       prio,
  output logic [NUM_LINES-PRIV_IDS-1:0][NUM_CPUS-1:0] tgt,
  output logic [NUM_LINES-1:0]                   edge_cfg,
  output logic                                   sgi_fire,
  output logic [3:0]                             sgi_id,
  output logic [NUM_CPUS-1:0]                    sgi_cpus
);
  localparam int NS = NUM_LINES - PRIV_IDS;
  localparam int NW = NUM_LINES / 32;

  logic                               ctrl_q;
  logic [NUM_CPUS-1:0][31:0]          priv_en_q;
  logic [NS-1:0]                      sh_en_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_q;
  logic [NS-1:0][NUM_CPUS-1:0]        tgt_q;
  logic [NUM_LINES-1:0]               edge_q;
  logic [31:0]                        rd_val;

  logic in_enset, in_enclr, in_prio, in_tgt, in_cfg;
  assign in_enset = addr[9:5] == PG_ENSET;
  assign in_enclr = addr[9:5] == PG_ENCLR;
  assign in_prio  = addr[9:8] == PG_PRIO;
  assign in_tgt   = addr[9:8] == PG_TGT;
  assign in_cfg   = addr[9:6] == PG_CFG;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 1'b0;
      priv_en_q <= '0;
      sh_en_q   <= '0;
      prio_q    <= '0;
      tgt_q     <= '0;
      edge_q    <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) ctrl_q <= wdata[0];
      for (int b = 0; b < 32; b++) begin
        if (in_enset && addr[4:0] == 5'd0 && wdata[b]) priv_en_q[cpu][b] <= 1'b1;
        if (in_enclr && addr[4:0] == 5'd0 && wdata[b]) priv_en_q[cpu][b] <= 1'b0;
      end
      for (int j = 0; j < NS; j++) begin
        if (in_enset && addr[4:0] == 5'(j/32 + 1) && wdata[j%32]) sh_en_q[j] <= 1'b1;
        if (in_enclr && addr[4:0] == 5'(j/32 + 1) && wdata[j%32]) sh_en_q[j] <= 1'b0;
        if (in_tgt && addr[7:0] == 8'(j/4 + 8))
          tgt_q[j] <= wdata[8*(j%4) +: NUM_CPUS];
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        if (in_prio && addr[7:0] == 8'(i/4)) prio_q[i] <= wdata[8*(i%4) +: 8];
        if (in_cfg && addr[5:0] == 6'(i/16)) edge_q[i] <= wdata[2*(i%16) + 1];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == A_CTRL) begin
      rd_val[0] = ctrl_q;
    end else if (addr == A_TYPE) begin
      rd_val[4:0] = 5'(NW - 1);
    end else if (in_enset || in_enclr) begin
      if (addr[4:0] == 5'd0) rd_val = priv_en_q[cpu];
      for (int j = 0; j < NS; j++)
        if (addr[4:0] == 5'(j/32 + 1)) rd_val[j%32] = sh_en_q[j];
    end else if (addr[9:5] == PG_PEND) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (addr[4:0] == 5'(i/32)) rd_val[i%32] = pend_view[cpu][i];
    end else if (addr[9:5] == PG_ACT) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (addr[4:0] == 5'(i/32)) rd_val[i%32] = act_view[cpu][i];
    end else if (in_prio) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (addr[7:0] == 8'(i/4)) rd_val[8*(i%4) +: 8] = prio_q[i];
    end else if (in_tgt) begin
      for (int j = 0; j < NS; j++)
        if (addr[7:0] == 8'(j/4 + 8)) rd_val[8*(j%4) +: NUM_CPUS] = tgt_q[j];
    end else if (in_cfg) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (addr[5:0] == 6'(i/16)) rd_val[2*(i%16) + 1] = edge_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) en_view[c] = {sh_en_q, priv_en_q[c]};
  end

  assign gen_en   = ctrl_q;
  assign prio     = prio_q;
  assign tgt      = tgt_q;
  assign edge_cfg = edge_q;
  assign sgi_fire = wr && (addr == A_SGI);
  assign sgi_id   = wdata[3:0];
  assign sgi_cpus = wdata[16 +: NUM_CPUS];
endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_LINES-PRIV_IDS-1:0]      spi_in,
  input  logic [NUM_CPUS*16-1:0]             priv_in,
  input  logic [NUM_LINES-1:0]               edge_cfg,
  input  logic                               sgi_fire,
  input  logic [3:0]                         sgi_id,
  input  logic [NUM_CPUS-1:0]                sgi_cpus,
  input  logic [NUM_CPUS-1:0]                ack_valid,
  input  logic [NUM_CPUS*ID_W-1:0]           ack_id,
  input  logic [NUM_CPUS-1:0]                eoi_valid,
  input  logic [NUM_CPUS*ID_W-1:0]           eoi_id,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0] pend_view,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0] act_view
);
  localparam int NS = NUM_LINES - PRIV_IDS;

  logic [NUM_CPUS-1:0][31:0] pp_q, pa_q, pp_n, pa_n;
  logic [NUM_CPUS-1:0][15:0] pin, pin_prev;
  logic [NS-1:0]             sp_q, sa_q, sp_n, sa_n, sin_prev;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) pin[c] = priv_in[16*c +: 16];
  end

  always_comb begin
    logic ah, eh;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int b = 0; b < 32; b++) begin
        ah = ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(b);
        eh = eoi_valid[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(b);
        pa_n[c][b] = (pa_q[c][b] & ~eh) | ah;
        if (b < SGI_IDS)
          pp_n[c][b] = (pp_q[c][b] | (sgi_fire && sgi_id == 4'(b) && sgi_cpus[c])) & ~ah;
        else if (edge_cfg[b])
          pp_n[c][b] = (pp_q[c][b] | (pin[c][b & 15] & ~pin_prev[c][b & 15])) & ~ah;
        else
          pp_n[c][b] = pin[c][b & 15] & ~pa_n[c][b];
      end
    end
    for (int j = 0; j < NS; j++) begin
      ah = 1'b0;
      eh = 1'b0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        ah = ah | (ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(j + PRIV_IDS));
        eh = eh | (eoi_valid[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(j + PRIV_IDS));
      end
      sa_n[j] = (sa_q[j] & ~eh) | ah;
      if (edge_cfg[j + PRIV_IDS])
        sp_n[j] = (sp_q[j] | (spi_in[j] & ~sin_prev[j])) & ~ah;
      else
        sp_n[j] = spi_in[j] & ~sa_n[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_q     <= '0;
      pa_q     <= '0;
      sp_q     <= '0;
      sa_q     <= '0;
      pin_prev <= '0;
      sin_prev <= '0;
    end else begin
      pp_q     <= pp_n;
      pa_q     <= pa_n;
      sp_q     <= sp_n;
      sa_q     <= sa_n;
      pin_prev <= pin;
      sin_prev <= spi_in;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      pend_view[c] = {sp_q, pp_q[c]};
      act_view[c]  = {sa_q, pa_q[c]};
    end
  end
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             gen_en,
  input  logic [NUM_LINES-1:0]             cand,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             win_valid,
  output logic [ID_W-1:0]                  win_id,
  output logic [PRIO_W-1:0]                win_prio
);
  logic              hit;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: lower ID keeps a tie
  always_comb begin
    hit     = 1'b0;
    best_id = ID_NONE;
    best_p  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (gen_en && cand[i] && (!hit || prio[i] < best_p)) begin
        hit     = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_id    <= ID_NONE;
      win_prio  <= '1;
    end else begin
      win_valid <= hit;
      win_id    <= best_id;
      win_prio  <= best_p;
    end
  end
endmodule

// File: rtl/irq_dist_top.sv
module irq_dist_top
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64,
  parameter int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [CPU_W-1:0]              reg_cpu,
  input  logic [9:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NUM_LINES-33:0]         spi_in,
  input  logic [NUM_CPUS*16-1:0]        priv_in,
  input  logic [NUM_CPUS-1:0]           ack_valid,
  input  logic [NUM_CPUS*10-1:0]        ack_id,
  input  logic [NUM_CPUS-1:0]           eoi_valid,
  input  logic [NUM_CPUS*10-1:0]        eoi_id,
  output logic [NUM_CPUS-1:0]           sel_valid,
  output logic [NUM_CPUS*10-1:0]        sel_id,
  output logic [NUM_CPUS*8-1:0]         sel_prio
);
  localparam int NS = NUM_LINES - PRIV_IDS;

  logic                                   gen_en;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]     en_view, pend_view, act_view, cand;
  logic [NUM_LINES-1:0][PRIO_W-1:0]       prio;
  logic [NS-1:0][NUM_CPUS-1:0]            tgt;
  logic [NUM_LINES-1:0]                   edge_cfg;
  logic                                   sgi_fire;
  logic [3:0]                             sgi_id;
  logic [NUM_CPUS-1:0]                    sgi_cpus;
  logic [NS-1:0]                          sh_pend;

  irq_dist_regs #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .CPU_W(CPU_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .cpu(reg_cpu), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pend_view(pend_view), .act_view(act_view),
    .gen_en(gen_en), .en_view(en_view), .prio(prio), .tgt(tgt), .edge_cfg(edge_cfg),
    .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_cpus(sgi_cpus)
  );

  irq_dist_pend #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .spi_in(spi_in), .priv_in(priv_in), .edge_cfg(edge_cfg),
    .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_cpus(sgi_cpus),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .pend_view(pend_view), .act_view(act_view)
  );

  assign sh_pend = pend_view[0][NUM_LINES-1:PRIV_IDS];

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      cand[c] = en_view[c] & pend_view[c] & ~act_view[c];
      for (int j = 0; j < NS; j++)
        cand[c][j + PRIV_IDS] = cand[c][j + PRIV_IDS] & tgt[j][c];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_arb
    irq_dist_arb #(.NUM_LINES(NUM_LINES)) u_arb (
      .clk(clk), .rst(rst), .gen_en(gen_en), .cand(cand[c]), .prio(prio),
      .win_valid(sel_valid[c]), .win_id(sel_id[c*10 +: 10]), .win_prio(sel_prio[c*8 +: 8])
    );
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      gen_en,
  input logic [NUM_CPUS-1:0]       sel_valid,
  input logic [NUM_CPUS*10-1:0]    sel_id,
  input logic [NUM_LINES-33:0]     spi_in,
  input logic [NUM_LINES-1:0]      edge_cfg,
  input logic [NUM_LINES-33:0]     sh_pend,
  input logic [NUM_CPUS-1:0]       ack_valid,
  input logic [NUM_CPUS*10-1:0]    ack_id
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !$past(gen_en) |-> sel_valid == '0); // R6

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      sel_valid[c] |-> sel_id[c*10 +: 10] < 10'(NUM_LINES)); // R7
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
      !sel_valid[c] |-> sel_id[c*10 +: 10] == 10'd1023); // R7
  end

  for (genvar j = 0; j < NUM_LINES - 32; j++) begin : g_line
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
      ($past(!spi_in[j]) && $past(!edge_cfg[j + 32])) |-> !sh_pend[j]); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(ack_valid[0] && ack_id[9:0] == 10'(j + 32)) |-> !sh_pend[j]); // R12
  end
endmodule

bind irq_dist_top irq_dist_chk #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/irq_dist_top_bench.sv
module irq_dist_top_bench;
  localparam int C = 2;
  localparam int L = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            reg_wr, reg_rd;
  logic [0:0]      reg_cpu;
  logic [9:0]      reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic [L-33:0]   spi_in;
  logic [C*16-1:0] priv_in;
  logic [C-1:0]    ack_valid, eoi_valid;
  logic [C*10-1:0] ack_id, eoi_id;
  logic [C-1:0]    sel_valid;
  logic [C*10-1:0] sel_id;
  logic [C*8-1:0]  sel_prio;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_dist_top #(.NUM_CPUS(C), .NUM_LINES(L)) u_irq_dist_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_cpu(reg_cpu),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_in(spi_in), .priv_in(priv_in), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .sel_valid(sel_valid),
    .sel_id(sel_id), .sel_prio(sel_prio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int cpu, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_cpu = 1'(cpu); reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_cpu = 1'(cpu); reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ack(input int cpu, input int id);
    @(negedge clk);
    ack_valid[cpu] = 1'b1; ack_id[cpu*10 +: 10] = 10'(id);
    @(negedge clk);
    ack_valid[cpu] = 1'b0;
  endtask

  task automatic eoi(input int cpu, input int id);
    @(negedge clk);
    eoi_valid[cpu] = 1'b1; eoi_id[cpu*10 +: 10] = 10'(id);
    @(negedge clk);
    eoi_valid[cpu] = 1'b0;
  endtask

  function automatic logic [31:0] sid(input int cpu);
    return {22'd0, sel_id[cpu*10 +: 10]};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid", {30'd0, sel_valid}, 32'd0);
    chk("R1 idle id", sid(0), 32'd1023);
    chk("R1 idle prio", {24'd0, sel_prio[7:0]}, 32'hFF);
    rd(0, 10'h000, d); chk("R1 ctrl", d, 32'd0);
    rd(0, 10'h108, d); chk("R1 prio", d, 32'd0);
    rd(0, 10'h041, d); chk("R1 enable", d, 32'd0);
    rd(0, 10'h001, d); chk("R5 type", d, 32'(L/32 - 1));
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(0, 10'h041, 32'h5);
    rd(0, 10'h041, d); chk("R2 set", d, 32'h5);
    wr(0, 10'h041, 32'h0);
    rd(0, 10'h041, d); chk("R2 zero write", d, 32'h5);
    wr(0, 10'h061, 32'h1);
    rd(0, 10'h061, d); chk("R2 clear", d, 32'h4);
    wr(0, 10'h061, 32'h4);
    rd(0, 10'h041, d); chk("R2 clear all", d, 32'h0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(0, 10'h10A, 32'h44332211);
    rd(0, 10'h10A, d); chk("R3 lanes", d, 32'h44332211);
    rd(0, 10'h10B, d); chk("R3 neighbour", d, 32'h0);
    wr(0, 10'h10A, 32'h0);
    wr(0, 10'h302, 32'hFFFFFFFF);
    rd(0, 10'h302, d); chk("R9 cfg field", d, 32'hAAAAAAAA);
    wr(0, 10'h302, 32'h0);
    wr(0, 10'h200, 32'hFFFFFFFF);
    rd(0, 10'h200, d); chk("R4 private tgt", d, 32'h0);
  endtask

  task automatic t_global_level();
    logic [31:0] d;
    wr(0, 10'h041, 32'h2);          // enable ID 33
    wr(0, 10'h208, 32'h00000100);   // ID 33 -> CPU0
    spi_in[1] = 1'b1;
    idle(3);
    chk("R6 off", {31'd0, sel_valid[0]}, 32'd0);
    wr(0, 10'h000, 32'h1);
    idle(3);
    chk("R6 on id", sid(0), 32'd33);
    chk("R4 not cpu1", {31'd0, sel_valid[1]}, 32'd0);
    spi_in[1] = 1'b0;
    idle(3);
    chk("R10 drop idle", {31'd0, sel_valid[0]}, 32'd0);
    rd(0, 10'h081, d); chk("R10 pend clear", d, 32'h0);
  endtask

  task automatic t_select_ack();
    logic [31:0] d;
    wr(0, 10'h041, 32'h300);        // IDs 40,41
    wr(0, 10'h20A, 32'h00000101);
    wr(0, 10'h10A, 32'h00002080);   // 40:0x80 41:0x20
    spi_in[8] = 1'b1; spi_in[9] = 1'b1;
    idle(3);
    chk("R7 lowest value", sid(0), 32'd41);
    chk("R7 prio out", {24'd0, sel_prio[7:0]}, 32'h20);
    wr(0, 10'h10A, 32'h00003030);
    idle(3);
    chk("R7 tie lower id", sid(0), 32'd40);
    ack(0, 40);
    idle(3);
    chk("R12 next after ack", sid(0), 32'd41);
    rd(0, 10'h0A1, d); chk("R12 active bit", d, 32'h100);
    rd(0, 10'h081, d); chk("R10 active not pending", d & 32'h100, 32'h0);
    eoi(0, 40);
    idle(3);
    chk("R12 eoi returns", sid(0), 32'd40);
    rd(0, 10'h0A1, d); chk("R12 active clear", d, 32'h0);
    spi_in[8] = 1'b0; spi_in[9] = 1'b0;
    idle(3);
    chk("R10 both dropped", {31'd0, sel_valid[0]}, 32'd0);
  endtask

  task automatic t_edge();
    wr(0, 10'h302, 32'h02000000);   // ID 44 edge
    wr(0, 10'h041, 32'h1000);
    wr(0, 10'h20B, 32'h00000001);
    @(negedge clk); spi_in[12] = 1'b1;
    @(negedge clk); spi_in[12] = 1'b0;
    idle(3);
    chk("R9 edge latched", sid(0), 32'd44);
    ack(0, 44);
    eoi(0, 44);
    idle(3);
    chk("R12 edge ack clears", {31'd0, sel_valid[0]}, 32'd0);
  endtask

  task automatic t_target();
    wr(0, 10'h041, 32'h10);         // ID 36
    wr(0, 10'h209, 32'h00000002);   // -> CPU1
    spi_in[4] = 1'b1;
    idle(3);
    chk("R4 cpu1 gets", sid(1), 32'd36);
    chk("R4 cpu0 none", {31'd0, sel_valid[0]}, 32'd0);
    spi_in[4] = 1'b0;
    idle(3);
  endtask

  task automatic t_bank();
    logic [31:0] d;
    wr(0, 10'h040, 32'h00100000);   // ID 20 for CPU0
    rd(1, 10'h040, d); chk("R8 cpu1 copy", d, 32'h0);
    rd(0, 10'h040, d); chk("R8 cpu0 copy", d, 32'h00100000);
    priv_in[16 + 4] = 1'b1;
    idle(3);
    chk("R8 cpu1 disabled", {31'd0, sel_valid[1]}, 32'd0);
    priv_in[4] = 1'b1;
    idle(3);
    chk("R8 cpu0 private", sid(0), 32'd20);
    priv_in = '0;
    idle(3);
  endtask

  task automatic t_sgi();
    logic [31:0] d;
    wr(1, 10'h040, 32'h8);          // ID 3 for CPU1
    wr(0, 10'h3C0, 32'h00020003);
    idle(3);
    chk("R11 cpu1 sgi", sid(1), 32'd3);
    chk("R11 cpu0 none", {31'd0, sel_valid[0]}, 32'd0);
    rd(1, 10'h080, d); chk("R11 cpu1 pend", d, 32'h8);
    rd(0, 10'h080, d); chk("R11 cpu0 pend", d, 32'h0);
    ack(1, 3);
    rd(1, 10'h080, d); chk("R12 sgi ack", d, 32'h0);
    eoi(1, 3);
    idle(3);
    chk("R12 sgi done", {31'd0, sel_valid[1]}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_cpu = '0; reg_addr = '0;
    reg_wdata = '0; spi_in = '0; priv_in = '0; ack_valid = '0; eoi_valid = '0;
    ack_id = '0; eoi_id = '0;
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_enable();
    t_lanes();
    t_global_level();
    t_select_ack();
    t_edge();
    t_target();
    t_bank();
    t_sgi();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule